// File: doc/BRIEF.md
# Two-Tap Saturating FIR Filter with Four-Phase Handshake

This block is a two-tap filter that works one call at a time. A requester presents an 8-bit unsigned sample and raises `start_i`. The unit adds four times that sample to three times the sample of the previous call. It clips the sum into a 6-bit non-negative range, presents the value on `result_o` and raises `done_o`. It keeps `done_o` high until the requester lowers `start_i`, then lowers `done_o` and waits for the next call.

The only state kept between calls is the previous sample already multiplied by three, held in a 10-bit tap register. The current call reads the old tap value first and writes the new one afterwards. Saturation does not compare the sum against limits. The 10-bit sum is truncated to 8 bits, and then bit 7 and bit 6 of that byte decide the outcome.

The controller is a five-state machine:
- ST_IDLE waits for start. On the clock edge where start is seen high it captures the sample.
- ST_SUM forms the truncated sum.
- ST_STORE writes the new tap.
- ST_CLIP registers the clipped result.
- ST_HOLD drives done high.

Its transitions are:
- idle→sum when start is high.
- sum→store, store→clip and clip→hold unconditionally.
- hold→idle when start is low.
- hold→hold while start stays high.
- idle→idle while start is low.

Top module: `fir2_top`

## Requirements
- R1: Reset (active-low `rst_n`) drives `done_o` and `result_o` to 0 and clears the tap, so the first call after reset uses a previous-sample contribution of 0.
- R2: The raw value is (4·sample + tap) modulo 1024, where tap = 3·(sample of the previous call); only its low 8 bits feed the clip stage.
- R3: If bit 7 of the 8-bit raw value is 1, `result_o` is 0.
- R4: Otherwise, if bit 6 of the 8-bit raw value is 1, `result_o` is 0x3F.
- R5: Otherwise `result_o` equals bits 5..0 of the raw value.
- R6: The tap changes only after the current sum has been formed from its old value; back-to-back calls each see the sample of the call just before.
- R7: `done_o` rises at the fourth rising clock edge counting the edge that first samples `start_i` high in idle, and stays low before it.
- R8: While `done_o` is high and `start_i` is high, `done_o` stays high; the first edge that samples `start_i` low lowers `done_o`.
- R9: `result_o` changes only on the edge at which `done_o` rises, so it holds from done's rise until the next call completes.
- R10: `sample_i` is captured only on the edge that first samples `start_i` high in idle; later changes during the call do not affect `result_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request line of the four-phase handshake |
| sample_i | input | 8 | Unsigned input sample |
| done_o | output | 1 | Acknowledge line of the four-phase handshake |
| result_o | output | 6 | Clipped filter output |

## Verification
The assertions rely on the requester following the four-phase protocol. They assume `start_i` stays high from its rise until `done_o` is seen high, and that it is then lowered and not raised again while `done_o` is still high. The latency and hold properties are only meaningful under that ordering. The bench drives `start_i` solely from one task that walks the four phases in order. Randomness goes only into the sample values, the length of the hold after done, the idle gap, and whether `sample_i` is disturbed mid-call. The protocol order itself is never randomised.

// File: rtl/fir2_pkg.sv
package fir2_pkg;

    // Sample and arithmetic widths
    parameter int SMP_W = 8;
    parameter int RAW_W = SMP_W + 2;   // holds 4*s + 3*s_prev modulo 2**RAW_W
    parameter int TST_W = 8;           // width after truncation, before the bit tests
    parameter int RES_W = TST_W - 2;   // clipped output width

    // Bit positions tested by the clip stage
    localparam int NEG_BIT = TST_W - 1;
    localparam int OVF_BIT = TST_W - 2;

    // Tap weights
    localparam int W_NOW  = 4;
    localparam int W_PREV = 3;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SUM   = 3'd1,
        ST_STORE = 3'd2,
        ST_CLIP  = 3'd3,
        ST_HOLD  = 3'd4
    } fir2_state_e;

    typedef struct packed {
        logic cap_en;
        logic sum_en;
        logic store_en;
        logic clip_en;
    } fir2_ctl_s;

endpackage

// File: rtl/fir2_ctrl.sv
module fir2_ctrl
    import fir2_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    output fir2_ctl_s   ctl_o,
    output logic        done_o,
    output fir2_state_e state_o
);

    fir2_state_e state_q;
    fir2_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_SUM;
            ST_SUM:   state_d = ST_STORE;
            ST_STORE: state_d = ST_CLIP;
            ST_CLIP:  state_d = ST_HOLD;
            ST_HOLD:  if (!start_i) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        ctl_o  = '0;
        done_o = 1'b0;
        unique case (state_q)
            ST_IDLE:  ctl_o.cap_en   = start_i;
            ST_SUM:   ctl_o.sum_en   = 1'b1;
            ST_STORE: ctl_o.store_en = 1'b1;
            ST_CLIP:  ctl_o.clip_en  = 1'b1;
            ST_HOLD:  done_o         = 1'b1;
            default:  done_o         = 1'b0;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/fir2_tap_path.sv
module fir2_tap_path
    import fir2_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  fir2_ctl_s        ctl_i,
    input  logic [SMP_W-1:0] sample_i,
    output logic [TST_W-1:0] raw_o,
    output logic [RAW_W-1:0] tap_o,
    output logic [SMP_W-1:0] smp_o
);

    logic [SMP_W-1:0] smp_q;
    logic [RAW_W-1:0] tap_q;
    logic [TST_W-1:0] raw_q;
    logic [RAW_W-1:0] sum_w;
    logic [RAW_W-1:0] next_tap_w;

    assign sum_w      = RAW_W'(W_NOW)  * RAW_W'(smp_q) + tap_q;
    assign next_tap_w = RAW_W'(W_PREV) * RAW_W'(smp_q);

    // Sample capture: only on the accepting edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q <= '0;
        end else if (ctl_i.cap_en) begin
            smp_q <= sample_i;
        end
    end

    // Truncated sum, formed from the old tap
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q <= '0;
        end else if (ctl_i.sum_en) begin
            raw_q <= TST_W'(sum_w);
        end
    end

    // Tap update, strictly after the sum
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tap_q <= '0;
        end else if (ctl_i.store_en) begin
            tap_q <= next_tap_w;
        end
    end

    assign raw_o = raw_q;
    assign tap_o = tap_q;
    assign smp_o = smp_q;

endmodule

// File: rtl/fir2_clip.sv
module fir2_clip
    import fir2_pkg::*;
(
    input  logic [TST_W-1:0] raw_i,
    output logic [RES_W-1:0] res_o
);

    always_comb begin
        if (raw_i[NEG_BIT]) begin
            res_o = '0;
        end else if (raw_i[OVF_BIT]) begin
            res_o = '1;
        end else begin
            res_o = raw_i[RES_W-1:0];
        end
    end

endmodule

// File: rtl/fir2_top.sv
module fir2_top
    import fir2_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [SMP_W-1:0] sample_i,
    output logic             done_o,
    output logic [RES_W-1:0] result_o
);

    fir2_ctl_s        ctl_w;
    fir2_state_e      st_w;
    logic [TST_W-1:0] raw_w;
    logic [RAW_W-1:0] tap_w;
    logic [SMP_W-1:0] smp_w;
    logic [RES_W-1:0] clip_w;
    logic [RES_W-1:0] result_q;

    fir2_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .ctl_o   (ctl_w),
        .done_o  (done_o),
        .state_o (st_w)
    );

    fir2_tap_path u_path (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_i    (ctl_w),
        .sample_i (sample_i),
        .raw_o    (raw_w),
        .tap_o    (tap_w),
        .smp_o    (smp_w)
    );

    fir2_clip u_clip (
        .raw_i (raw_w),
        .res_o (clip_w)
    );

    // Result register: loaded once per call, on the edge that enters ST_HOLD
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
        end else if (ctl_w.clip_en) begin
            result_q <= clip_w;
        end
    end

    assign result_o = result_q;

endmodule

// File: rtl/fir2_chk.sv
module fir2_chk
    import fir2_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             done_o,
    input logic [RES_W-1:0] result_o,
    input logic [RAW_W-1:0] tap,
    input logic [SMP_W-1:0] smp,
    input fir2_state_e      st
);

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && start_i) |=> done_o);

    // R8
    done_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> !done_o);

    // R9
    result_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result_o) |-> $rose(done_o));

    // R7
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(start_i, 4));

    // R6
    tap_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tap) |-> ($past(st) == ST_STORE));

    // R10
    smp_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(smp) |-> ($past(st) == ST_IDLE && $past(start_i)));

endmodule

bind fir2_top fir2_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .done_o   (done_o),
    .result_o (result_o),
    .tap      (tap_w),
    .smp      (smp_w),
    .st       (st_w)
);

// File: tb/test_fir2_top.sv
`timescale 1ns/1ps
module test_fir2_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] sample_i = '0;
    logic       done_o;
    logic [5:0] result_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    int model_tap = 0;

    always #2 clk = ~clk;   // 250 MHz

    fir2_top i_fir2_top (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .sample_i (sample_i),
        .done_o   (done_o),
        .result_o (result_o)
    );

    function automatic int raw8_of(input int s, input int tap);
        return ((4 * s + tap) % 1024) % 256;
    endfunction

    function automatic int clip_of(input int r8);
        if (r8 >= 128) return 0;
        if (r8 >= 64)  return 63;
        return r8 % 64;
    endfunction

    function automatic string tag_of(input int r8);
        if (r8 >= 128) return "R3";
        if (r8 >= 64)  return "R4";
        return "R5";
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        start_i = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_tap = 0;
        @(negedge clk);
        chk(done_o == 1'b0, "R1 done after reset", int'(done_o), 0);
        chk(result_o == 6'd0, "R1 result after reset", int'(result_o), 0);
    endtask

    // One complete four-phase call
    task automatic run_op(input int s, input bit wiggle, input int hold, input string note);
        int r8;
        int exp;
        r8 = raw8_of(s, model_tap);
        exp = clip_of(r8);
        @(negedge clk);
        sample_i = 8'(s);
        start_i = 1'b1;
        for (int i = 1; i <= 4; i++) begin
            @(negedge clk);
            if (wiggle) sample_i = 8'($urandom);
            if (i < 4) chk(done_o == 1'b0, "R7 done early", int'(done_o), 0);
            else       chk(done_o == 1'b1, "R7 done at 4th edge", int'(done_o), 1);
        end
        chk(result_o == 6'(exp), {tag_of(r8), " R2 R6 ", note, wiggle ? " R10" : ""},
            int'(result_o), exp);
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(done_o == 1'b1, "R8 done held", int'(done_o), 1);
            chk(result_o == 6'(exp), "R9 result held", int'(result_o), exp);
        end
        start_i = 1'b0;
        @(negedge clk);
        chk(done_o == 1'b0, "R8 done dropped", int'(done_o), 0);
        chk(result_o == 6'(exp), "R9 result after drop", int'(result_o), exp);
        for (int g = 0; g < int'($urandom_range(2, 0)); g++) begin
            sample_i = 8'($urandom);
            @(negedge clk);
            chk(result_o == 6'(exp), "R9 R10 idle", int'(result_o), exp);
        end
        model_tap = 3 * s;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        do_reset();                       // R1
        run_op(15, 1'b0, 0, "first call uses zero tap");   // 60 -> R5, R1
        run_op(16, 1'b0, 2, "bit6 clip");                  // 109 -> R4
        run_op(32, 1'b0, 1, "bit7 clip");                  // 176 -> R3
        run_op(255, 1'b0, 0, "max");
        run_op(255, 1'b1, 3, "wrap");                      // 1785 -> R2
        do_reset();
        run_op(200, 1'b0, 0, "truncation");                // 800 -> 32, R2
        run_op(0, 1'b1, 1, "zero sample");
        run_op(1, 1'b0, 0, "small");
        for (int k = 0; k < 300; k++) begin
            run_op(int'($urandom_range(255, 0)), 1'($urandom), int'($urandom_range(3, 0)), "random");
        end
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule